// File: doc/BRIEF.md
# Over-Current Trip and Retry Sequencer

This block guards the regulated output of a wireless power receiver against load over-current. It watches a stream of digitized load-current samples (0.5 mA per code) and compares each one with a trip level picked from a small table of settings. One setting switches the protection off. When the load stays above the chosen level for two valid samples in a row, the block latches a trip. It asks the output stage to shut down. It also asks the link layer to send an end-of-power-transfer packet that carries the over-current reason code.

The link layer reports the end of every packet with a one-cycle strobe. A response flag on that strobe tells whether the transmitter acted. If the transmitter did not act, the block raises the request again for another copy of the packet. It stops after twelve copies in total. It then keeps the system shut down and sets a sticky "retries exhausted" status bit. Only dropping and raising the enable input brings the block back to its idle state.

Top module: `oc_trip_sequencer`

## Requirements
- R1: After reset, `ept_req_o` and `shutdown_o` are 0 and every bit of `status_o` is 0. The status layout is: bits [3:0] attempt count, bit 4 tripped, bit 5 acknowledged, bit 6 exhausted.
- R2: `thr_sel_i` codes 1, 2 and 3 set trip levels of 520, 1080 and 1560 sample codes (260, 540 and 780 mA at 0.5 mA per code). A sample counts as over only when it is strictly greater than the level.
- R3: A trip needs two consecutive valid over samples. A valid sample that is not over restarts the count. Cycles with `sample_vld_i` low neither advance nor break the count.
- R4: `thr_sel_i` = 0 disables protection. No sample value causes a trip, and any partial count is discarded.
- R5: On the clock edge that captures the second over sample, `shutdown_o`, `ept_req_o` and the tripped status bit rise together. `ept_code_o` reads 0x05 while `ept_req_o` is high.
- R6: A `pkt_done_i` strobe with `pkt_ack_i` = 1 during a request ends the sequence. It increments the attempt count, sets the acknowledged bit, and drops `ept_req_o` for good.
- R7: A `pkt_done_i` strobe with `pkt_ack_i` = 0 during a request increments the attempt count. It drops `ept_req_o` for exactly one cycle and then raises it again.
- R8: After the twelfth unacknowledged attempt, the exhausted bit is set and stays set. `ept_req_o` stays low, the count stays at 12, and later strobes change nothing.
- R9: After a trip, `shutdown_o` stays high whatever the samples or the threshold selection do. Only `en_i` = 0 returns the block to the R1 state.
- R10: A `pkt_done_i` strobe while no request is pending has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable; low clears all state |
| thr_sel_i | input | 2 | Trip level select: 0 off, 1 low, 2 mid, 3 high |
| sample_i | input | SAMPLE_W (12) | Load current, 0.5 mA per code |
| sample_vld_i | input | 1 | Sample valid strobe |
| pkt_done_i | input | 1 | Link layer: packet finished |
| pkt_ack_i | input | 1 | Transmitter acted on the packet, qualified by `pkt_done_i` |
| ept_req_o | output | 1 | Request to send the end-of-transfer packet |
| ept_code_o | output | 8 | Reason code carried by the packet (0x05) |
| shutdown_o | output | 1 | Force the regulated output to high impedance |
| status_o | output | CNT_W+3 (7) | Attempt count, tripped, acknowledged, exhausted |

## Verification
The hardest state to reach is the exhausted state. Getting there takes a confirmed trip and then twelve complete request cycles, each closed by a done strobe with the response flag low. The bench reaches it with a loop. Each pass pulses done, checks that the request drops for one cycle and comes back, and checks the count. After the twelfth pass it sends extra strobes, including one with the response flag high, to show that the state is frozen. The two-sample filter is pushed to its edges with samples exactly at the level, with gaps in the valid strobe, and with a selection change in the middle of a streak.

// File: rtl/oc_pkg.sv
package oc_pkg;

    // Sample scale: two codes per milliampere (0.5 mA per code)
    localparam int CODES_PER_MA = 2;

    // Reason code for an over-current end-of-transfer packet
    localparam logic [7:0] EPT_REASON_OC = 8'h05;

    // Selectable trip levels, in mA
    localparam int LVL_LOW_MA  = 260;
    localparam int LVL_MID_MA  = 540;
    localparam int LVL_HIGH_MA = 780;

    typedef enum logic [1:0] {
        SEL_OFF  = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_MID  = 2'd2,
        SEL_HIGH = 2'd3
    } oc_sel_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEND    = 3'd1,
        ST_GAP     = 3'd2,
        ST_ACKED   = 3'd3,
        ST_EXHAUST = 3'd4
    } oc_state_e;

    typedef struct packed {
        logic exhausted;
        logic acked;
        logic tripped;
    } oc_flags_t;

    // Trip level in sample codes for a selection; 0 when protection is off
    function automatic logic [15:0] level_codes(input oc_sel_e sel);
        case (sel)
            SEL_LOW:  level_codes = 16'(LVL_LOW_MA  * CODES_PER_MA);
            SEL_MID:  level_codes = 16'(LVL_MID_MA  * CODES_PER_MA);
            SEL_HIGH: level_codes = 16'(LVL_HIGH_MA * CODES_PER_MA);
            default:  level_codes = 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/oc_threshold_cmp.sv
module oc_threshold_cmp
    import oc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int TRIP_CNT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic                armed_i,
    input  oc_sel_e             sel_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_vld_i,
    output logic                trip_o
);
    localparam int SW    = $clog2(TRIP_CNT + 1);
    localparam int CMP_W = (SAMPLE_W > 16) ? SAMPLE_W : 16;

    logic [SW-1:0] streak_q;
    logic          active;
    logic          over;
    logic          last_needed;

    assign active      = en_i && armed_i && (sel_i != SEL_OFF);
    assign over        = CMP_W'(sample_i) > CMP_W'(level_codes(sel_i));
    assign last_needed = streak_q >= SW'(TRIP_CNT - 1);
    assign trip_o      = active && sample_vld_i && over && last_needed;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            streak_q <= '0;
        end else if (sample_vld_i) begin
            if (!over)
                streak_q <= '0;
            else if (!last_needed)
                streak_q <= streak_q + SW'(1);
        end
    end
endmodule

// File: rtl/oc_retry_fsm.sv
module oc_retry_fsm
    import oc_pkg::*;
#(
    parameter int MAX_TRIES = 12,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             trip_i,
    input  logic             done_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic             shutdown_o,
    output logic [CNT_W-1:0] attempts_o,
    output oc_flags_t        flags_o
);
    oc_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    oc_flags_t        flags_q, flags_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        flags_d = flags_q;
        case (state_q)
            ST_IDLE: begin
                if (trip_i) begin
                    state_d         = ST_SEND;
                    flags_d.tripped = 1'b1;
                end
            end
            ST_SEND: begin
                if (done_i) begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (ack_i) begin
                        state_d       = ST_ACKED;
                        flags_d.acked = 1'b1;
                    end else if (cnt_d == CNT_W'(MAX_TRIES)) begin
                        state_d           = ST_EXHAUST;
                        flags_d.exhausted = 1'b1;
                    end else begin
                        state_d = ST_GAP;
                    end
                end
            end
            ST_GAP:  state_d = ST_SEND;
            default: state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            flags_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            flags_q <= flags_d;
        end
    end

    assign req_o      = (state_q == ST_SEND);
    assign shutdown_o = (state_q != ST_IDLE);
    assign attempts_o = cnt_q;
    assign flags_o    = flags_q;
endmodule

// File: rtl/oc_trip_sequencer.sv
module oc_trip_sequencer
    import oc_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int TRIP_CNT  = 2,
    parameter int MAX_TRIES = 12,
    parameter int CNT_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic [1:0]          thr_sel_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                sample_vld_i,
    input  logic                pkt_done_i,
    input  logic                pkt_ack_i,
    output logic                ept_req_o,
    output logic [7:0]          ept_code_o,
    output logic                shutdown_o,
    output logic [CNT_W+2:0]    status_o
);
    logic             trip;
    logic             shut;
    logic [CNT_W-1:0] attempts;
    oc_flags_t        flags;

    oc_threshold_cmp #(
        .SAMPLE_W (SAMPLE_W),
        .TRIP_CNT (TRIP_CNT)
    ) i_cmp (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en_i),
        .armed_i      (!shut),
        .sel_i        (oc_sel_e'(thr_sel_i)),
        .sample_i     (sample_i),
        .sample_vld_i (sample_vld_i),
        .trip_o       (trip)
    );

    oc_retry_fsm #(
        .MAX_TRIES (MAX_TRIES),
        .CNT_W     (CNT_W)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en_i),
        .trip_i     (trip),
        .done_i     (pkt_done_i),
        .ack_i      (pkt_ack_i),
        .req_o      (ept_req_o),
        .shutdown_o (shut),
        .attempts_o (attempts),
        .flags_o    (flags)
    );

    assign shutdown_o = shut;
    assign ept_code_o = EPT_REASON_OC;
    assign status_o   = {flags.exhausted, flags.acked, flags.tripped, attempts};
endmodule

// File: rtl/oc_trip_sequencer_chk.sv
module oc_trip_sequencer_chk #(
    parameter int MAX_TRIES = 12,
    parameter int CNT_W     = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en_i,
    input logic [1:0]       thr_sel_i,
    input logic             sample_vld_i,
    input logic             pkt_done_i,
    input logic             ept_req_o,
    input logic [7:0]       ept_code_o,
    input logic             shutdown_o,
    input logic [CNT_W+2:0] status_o
);
    logic [CNT_W-1:0] cnt;
    logic             exh;
    assign cnt = status_o[CNT_W-1:0];
    assign exh = status_o[CNT_W+2];

    assert_req_implies_shutdown_R5: assert property (@(posedge clk) disable iff (rst)
        ept_req_o |-> (shutdown_o && ept_code_o == 8'h05));

    assert_trip_needs_level_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(shutdown_o) |-> ($past(thr_sel_i) != 2'd0 && $past(sample_vld_i)));

    assert_req_drops_after_done_R6: assert property (@(posedge clk) disable iff (rst)
        (ept_req_o && pkt_done_i && en_i) |=> !ept_req_o);

    assert_cnt_moves_on_done_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> ($past(pkt_done_i) || !$past(en_i)));

    assert_attempts_bound_R8: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(MAX_TRIES));

    assert_exhausted_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (exh && en_i) |=> (exh && !ept_req_o));

    assert_shutdown_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (shutdown_o && en_i) |=> shutdown_o);
endmodule

bind oc_trip_sequencer oc_trip_sequencer_chk #(
    .MAX_TRIES (MAX_TRIES),
    .CNT_W     (CNT_W)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .thr_sel_i    (thr_sel_i),
    .sample_vld_i (sample_vld_i),
    .pkt_done_i   (pkt_done_i),
    .ept_req_o    (ept_req_o),
    .ept_code_o   (ept_code_o),
    .shutdown_o   (shutdown_o),
    .status_o     (status_o)
);

// File: tb/test_oc_trip_sequencer.sv
module test_oc_trip_sequencer;
    localparam int SAMPLE_W = 12;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                en_i = 1'b0;
    logic [1:0]          thr_sel_i = 2'd0;
    logic [SAMPLE_W-1:0] sample_i = '0;
    logic                sample_vld_i = 1'b0;
    logic                pkt_done_i = 1'b0;
    logic                pkt_ack_i = 1'b0;
    logic                ept_req_o;
    logic [7:0]          ept_code_o;
    logic                shutdown_o;
    logic [6:0]          status_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;  // 50 MHz

    oc_trip_sequencer i_oc_trip_sequencer (
        .clk          (clk),
        .rst          (rst),
        .en_i         (en_i),
        .thr_sel_i    (thr_sel_i),
        .sample_i     (sample_i),
        .sample_vld_i (sample_vld_i),
        .pkt_done_i   (pkt_done_i),
        .pkt_ack_i    (pkt_ack_i),
        .ept_req_o    (ept_req_o),
        .ept_code_o   (ept_code_o),
        .shutdown_o   (shutdown_o),
        .status_o     (status_o)
    );

    // status layout: [3:0] attempts, [4] tripped, [5] acked, [6] exhausted
    function automatic logic [6:0] st(int n, bit t, bit a, bit x);
        return {x, a, t, 4'(n)};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic sample(int v);
        @(negedge clk);
        sample_i = SAMPLE_W'(v);
        sample_vld_i = 1'b1;
        @(negedge clk);
        sample_vld_i = 1'b0;
    endtask

    task automatic done(bit ack);
        @(negedge clk);
        pkt_done_i = 1'b1;
        pkt_ack_i = ack;
        @(negedge clk);
        pkt_done_i = 1'b0;
        pkt_ack_i = 1'b0;
    endtask

    task automatic reenable();
        @(negedge clk);
        en_i = 1'b0;
        @(negedge clk);
        en_i = 1'b1;
    endtask

    task automatic test_reset();
        chk("R1", "req", ept_req_o, 0);
        chk("R1", "shutdown", shutdown_o, 0);
        chk("R1", "status", status_o, 0);
    endtask

    task automatic test_filter_r3();
        thr_sel_i = 2'd1;
        sample(600);
        sample(100);
        sample(600);
        chk("R3", "broken streak no trip", shutdown_o, 0);
        repeat (3) @(negedge clk);
        sample(600);
        chk("R3", "gap keeps streak, trip", shutdown_o, 1);
        chk("R5", "req on trip", ept_req_o, 1);
        chk("R5", "reason code", ept_code_o, 8'h05);
        chk("R5", "status tripped", status_o, st(0, 1, 0, 0));
        reenable();
    endtask

    task automatic test_levels_r2();
        thr_sel_i = 2'd1;
        sample(520); sample(520);
        chk("R2", "low level equal no trip", shutdown_o, 0);
        sample(521);
        chk("R2", "low level single over", shutdown_o, 0);
        sample(521);
        chk("R2", "low level 521 trips", shutdown_o, 1);
        reenable();
        thr_sel_i = 2'd2;
        sample(1080); sample(1080); sample(1000);
        chk("R2", "mid level at level", shutdown_o, 0);
        sample(1081); sample(1081);
        chk("R2", "mid level trips", shutdown_o, 1);
        reenable();
        thr_sel_i = 2'd3;
        sample(1560); sample(1560);
        chk("R2", "high level at level", shutdown_o, 0);
        sample(1561); sample(4000);
        chk("R2", "high level trips", shutdown_o, 1);
        reenable();
    endtask

    task automatic test_disable_r4();
        thr_sel_i = 2'd0;
        for (int i = 0; i < 5; i++) sample(4095);
        chk("R4", "off no trip", shutdown_o, 0);
        thr_sel_i = 2'd1;
        sample(600);
        thr_sel_i = 2'd0;
        sample(600);
        thr_sel_i = 2'd1;
        sample(600);
        chk("R4", "off discards streak", shutdown_o, 0);
        sample(600);
        chk("R4", "trips after streak rebuilt", shutdown_o, 1);
        reenable();
    endtask

    task automatic test_ack_r6();
        done(1'b0);
        chk("R10", "done while idle ignored", status_o, 0);
        thr_sel_i = 2'd1;
        sample(700); sample(700);
        done(1'b0);
        chk("R7", "req gap after done", ept_req_o, 0);
        chk("R7", "count after first", status_o, st(1, 1, 0, 0));
        @(negedge clk);
        chk("R7", "req returns", ept_req_o, 1);
        done(1'b0);
        @(negedge clk);
        done(1'b1);
        chk("R6", "acked status", status_o, st(3, 1, 1, 0));
        chk("R6", "req off", ept_req_o, 0);
        repeat (3) @(negedge clk);
        chk("R6", "req stays off", ept_req_o, 0);
        done(1'b0);
        chk("R10", "done after ack ignored", status_o, st(3, 1, 1, 0));
        thr_sel_i = 2'd0;
        sample(0); sample(0);
        chk("R9", "shutdown held", shutdown_o, 1);
        reenable();
        chk("R9", "enable low clears", status_o, 0);
        chk("R9", "shutdown cleared", shutdown_o, 0);
    endtask

    task automatic test_exhaust_r8();
        thr_sel_i = 2'd3;
        sample(2000); sample(2000);
        for (int i = 1; i <= 12; i++) begin
            chk("R7", "req before done", ept_req_o, 1);
            done(1'b0);
            chk("R7", "count", int'(status_o[3:0]), i);
            if (i < 12) @(negedge clk);
        end
        chk("R8", "exhausted status", status_o, st(12, 1, 0, 1));
        chk("R8", "req off", ept_req_o, 0);
        done(1'b1);
        done(1'b0);
        repeat (4) @(negedge clk);
        chk("R8", "frozen after extra strobes", status_o, st(12, 1, 0, 1));
        chk("R8", "shutdown held", shutdown_o, 1);
        chk("R8", "no new req", ept_req_o, 0);
        reenable();
        chk("R9", "re-enable clears exhausted", status_o, 0);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        en_i = 1'b1;
        @(negedge clk);
        test_reset();
        test_filter_r3();
        test_levels_r2();
        test_disable_r4();
        test_ack_r6();
        test_exhaust_r8();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule